// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block turns single requests from a 16-bit processor core into four-phase external bus cycles. Each cycle runs through phases T1, T2, T3 and T4: the address goes out in T1 and data moves in T2 to T4. The block drives two buses. The first is a shared address/data bus, on which the address and the data take turns. The second is a separate address bus that holds the address for the whole cycle. In byte-wide mode, a set of dedicated upper-address lines also carries address bits 15 to 8.

Two memory regions, upper and lower, each have their own configuration bit that removes the address from the shared bus. When the bit of the accessed region is set, the shared bus stays in high impedance during T1. This saves switching power, and the shared bus then behaves as a data-only bus. A strap pin is captured when reset is released. If the strap is low, both bits are overruled and every access drives the address in T1. Every driven bus has its own output enable, so every high-impedance interval is visible at the pins.

The core handshake is simple. A request is taken only when the sequencer is idle. A one-cycle done pulse in T4 ends the access, and for a read that pulse carries the captured data.

Top module: `mux_bus_seq`

## Requirements
- R1: An accepted request runs the phases T1, T2, T3, T4 on consecutive cycles and then returns to idle. The `bus_phase` encoding is 0 = idle, 1 = T1, 2 = T2, 3 = T3, 4 = T4.
- R2: When the address is not suppressed, `ad_oe` is high in T1 and `ad_out` equals the address bits 15:0 in that phase.
- R3: `ab_oe` is high and `ab_out` equals the full request address in every phase from T1 to T4, and `ab_out` stays unchanged across them.
- R4: The address is suppressed when `req_region` is 2'b01 (lower region) and `cfg_lo_addr_off` is 1, or when `req_region` is 2'b10 (upper region) and `cfg_hi_addr_off` is 1. A suppressed access has `ad_oe` low in T1.
- R5: Each configuration bit acts only on its own region code. Region codes 2'b00 and 2'b11 always drive the address in T1.
- R6: If `strap_addr_drive` was low when reset was released, no access is ever suppressed, whatever the configuration bits are.
- R7: The strap is captured in the cycle in which reset is released. Later changes on the strap pin have no effect until the next reset.
- R8: For a write, `ad_oe` is high in T2 to T4 and `ad_out` carries the write data. For a read, `ad_oe` is low in T2 to T4 and `ad_in` is captured at the end of T3. In byte mode only bits 7:0 are used for data, and the other bits read as 0.
- R9: `done` is high for exactly one cycle, in T4. For a read, `rdata` holds the captured value in that cycle.
- R10: `req_ready` is high only while the sequencer is idle. A `req_valid` raised while a cycle is running is ignored, and that cycle keeps its own address.
- R11: In byte mode (`req_byte` = 1), `ahi_oe` is high in T2 to T4 and `ahi_out` equals address bits 15:8, whatever the configuration bits are. In T1, `ahi_oe` is high only when the address is not suppressed. In word mode `ahi_oe` stays low.
- R12: After reset the sequencer is idle with `req_ready` high, `done` low and all three output enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_addr_drive | input | 1 | Strap, captured when reset is released; low forces the address onto the shared bus |
| req_valid | input | 1 | Core request strobe |
| req_ready | output | 1 | Sequencer is idle and can take a request |
| req_addr | input | 20 | Request address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte-wide bus mode |
| req_region | input | 2 | Region code: 01 = lower, 10 = upper, others = other space |
| cfg_lo_addr_off | input | 1 | Suppress the address for lower-region accesses |
| cfg_hi_addr_off | input | 1 | Suppress the address for upper-region accesses |
| done | output | 1 | One-cycle completion pulse in T4 |
| rdata | output | 16 | Captured read data |
| bus_phase | output | 3 | Current phase: 0 idle, 1 to 4 for T1 to T4 |
| ad_out | output | 16 | Shared address/data bus, output value |
| ad_oe | output | 1 | Output enable for the shared bus |
| ad_in | input | 16 | Shared address/data bus, input value |
| ab_out | output | 20 | Separate address bus |
| ab_oe | output | 1 | Output enable for the separate address bus |
| ahi_out | output | 8 | Upper address lines for byte mode |
| ahi_oe | output | 1 | Output enable for the upper address lines |

## Verification
A request sampled at a clock edge puts T1 on the pins one cycle later, and T2, T3 and T4 follow one cycle apart. Read data is taken at the edge that ends T3 and is visible with `done` in T4. The bench raises `req_valid` at a falling edge and then checks each phase at the next falling edges. Every output enable and bus value is compared in the cycle in which the requirements place it. The idle cycle after T4 is checked too, to confirm that the cycle did not restart and that a request held during the cycle was ignored.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_T4   = 3'd4
  } phase_e;

  localparam logic [1:0] RGN_LOWER = 2'b01;
  localparam logic [1:0] RGN_UPPER = 2'b10;

  // Address is kept off the shared bus in T1 when the strap allows it and
  // the accessed region has its own suppress bit set.
  function automatic logic addr_suppressed(input logic [1:0] rgn,
                                           input logic       lo_off,
                                           input logic       hi_off,
                                           input logic       strap_hi);
    logic hit;
    hit = ((rgn == RGN_LOWER) && lo_off) || ((rgn == RGN_UPPER) && hi_off);
    return strap_hi && hit;
  endfunction

  function automatic logic in_data_phase(input phase_e ph);
    return (ph == PH_T2) || (ph == PH_T3) || (ph == PH_T4);
  endfunction

endpackage

// File: rtl/mbs_phase_ctl.sv
module mbs_phase_ctl
  import mbs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output logic   accept,
  output phase_e phase
);

  assign accept = (phase == PH_IDLE) && start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE: if (start) phase <= PH_T1;
        PH_T1:   phase <= PH_T2;
        PH_T2:   phase <= PH_T3;
        PH_T3:   phase <= PH_T4;
        PH_T4:   phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_T1_TO_T2: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_T1 |=> phase == PH_T2); // R1
  AST_T3_TO_T4: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_T3 |=> phase == PH_T4); // R1
  AST_T4_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_T4 |=> phase == PH_IDLE); // R1
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    phase != PH_IDLE |=> phase != PH_T1); // R10

endmodule

// File: rtl/mbs_strap_latch.sv
module mbs_strap_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_pin,
  output logic strap_q
);

  logic run_q;

  // Follows the pin while reset is held, so the value frozen is the one seen
  // at the edge where reset is released.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strap_q <= strap_pin;
      run_q   <= 1'b0;
    end else begin
      run_q   <= 1'b1;
    end
  end

  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> $stable(strap_q)); // R7

endmodule

// File: rtl/mbs_req_reg.sv
module mbs_req_reg
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic              in_write,
  input  logic              in_byte,
  input  logic              in_suppress,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              write_q,
  output logic              byte_q,
  output logic              suppress_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q     <= '0;
      wdata_q    <= '0;
      write_q    <= 1'b0;
      byte_q     <= 1'b0;
      suppress_q <= 1'b0;
    end else if (accept) begin
      addr_q     <= in_addr;
      wdata_q    <= in_wdata;
      write_q    <= in_write;
      byte_q     <= in_byte;
      suppress_q <= in_suppress;
    end
  end

endmodule

// File: rtl/mbs_pin_drive.sv
module mbs_pin_drive
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic              write_q,
  input  logic              byte_q,
  input  logic              suppress_q,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-1:0] ab_out,
  output logic              ab_oe,
  output logic [DATA_W/2-1:0] ahi_out,
  output logic              ahi_oe
);

  localparam int HI_W = DATA_W / 2;

  logic addr_slot;
  logic data_slot;
  logic busy;

  assign addr_slot = (phase == PH_T1);
  assign data_slot = in_data_phase(phase);
  assign busy      = addr_slot || data_slot;

  always_comb begin
    ad_out = '0;
    if (addr_slot) begin
      ad_out = addr_q[DATA_W-1:0];
    end else if (data_slot && write_q) begin
      ad_out = byte_q ? {{HI_W{1'b0}}, wdata_q[HI_W-1:0]} : wdata_q;
    end
  end

  assign ad_oe   = (addr_slot && !suppress_q) || (data_slot && write_q);
  assign ab_out  = addr_q;
  assign ab_oe   = busy;
  assign ahi_out = addr_q[DATA_W-1:HI_W];
  assign ahi_oe  = byte_q && ((addr_slot && !suppress_q) || data_slot);

  AST_AB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    data_slot |-> ab_oe && $stable(ab_out)); // R3
  AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (data_slot && !write_q) |-> !ad_oe); // R8
  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_T3 && write_q) |-> ad_oe && $stable(ad_out)); // R8
  AST_BYTE_UPPER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (data_slot && byte_q) |-> ahi_oe); // R11
  AST_WORD_NO_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_q |-> !ahi_oe); // R11

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strap_addr_drive,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic                req_write,
  input  logic                req_byte,
  input  logic [1:0]          req_region,
  input  logic                cfg_lo_addr_off,
  input  logic                cfg_hi_addr_off,
  output logic                done,
  output logic [DATA_W-1:0]   rdata,
  output logic [2:0]          bus_phase,
  output logic [DATA_W-1:0]   ad_out,
  output logic                ad_oe,
  input  logic [DATA_W-1:0]   ad_in,
  output logic [ADDR_W-1:0]   ab_out,
  output logic                ab_oe,
  output logic [DATA_W/2-1:0] ahi_out,
  output logic                ahi_oe
);

  localparam int HI_W = DATA_W / 2;

  phase_e              phase;
  logic                accept;
  logic                strap_q;
  logic                suppress_now;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic                write_q;
  logic                byte_q;
  logic                suppress_q;
  logic [DATA_W-1:0]   rdata_q;
  logic                capture_evt;

  mbs_strap_latch u_strap (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_pin (strap_addr_drive),
    .strap_q   (strap_q)
  );

  mbs_phase_ctl u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (req_valid),
    .accept (accept),
    .phase  (phase)
  );

  assign suppress_now = addr_suppressed(req_region, cfg_lo_addr_off,
                                        cfg_hi_addr_off, strap_q);

  mbs_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .in_addr     (req_addr),
    .in_wdata    (req_wdata),
    .in_write    (req_write),
    .in_byte     (req_byte),
    .in_suppress (suppress_now),
    .addr_q      (addr_q),
    .wdata_q     (wdata_q),
    .write_q     (write_q),
    .byte_q      (byte_q),
    .suppress_q  (suppress_q)
  );

  mbs_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .addr_q     (addr_q),
    .wdata_q    (wdata_q),
    .write_q    (write_q),
    .byte_q     (byte_q),
    .suppress_q (suppress_q),
    .ad_out     (ad_out),
    .ad_oe      (ad_oe),
    .ab_out     (ab_out),
    .ab_oe      (ab_oe),
    .ahi_out    (ahi_out),
    .ahi_oe     (ahi_oe)
  );

  // Read data is taken at the edge that closes T3.
  assign capture_evt = (phase == PH_T3) && !write_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture_evt) begin
      rdata_q <= byte_q ? {{HI_W{1'b0}}, ad_in[HI_W-1:0]} : ad_in;
    end
  end

  assign rdata     = rdata_q;
  assign done      = (phase == PH_T4);
  assign req_ready = (phase == PH_IDLE);
  assign bus_phase = phase;

  AST_STRAP_FORCES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (!strap_q && phase == PH_T1) |-> ad_oe); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_OTHER_REGION_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_region != RGN_LOWER && req_region != RGN_UPPER) |=> ad_oe); // R5
  AST_READY_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !ab_oe); // R10

endmodule

// File: tb/mux_bus_seq_bench.sv
module mux_bus_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_write = 1'b0;
  logic        req_byte = 1'b0;
  logic [1:0]  req_region = '0;
  logic        cfg_lo = 1'b0;
  logic        cfg_hi = 1'b0;
  logic        done;
  logic [15:0] rdata;
  logic [2:0]  bus_phase;
  logic [15:0] ad_out;
  logic        ad_oe;
  logic [15:0] ad_in = '0;
  logic [19:0] ab_out;
  logic        ab_oe;
  logic [7:0]  ahi_out;
  logic        ahi_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  mux_bus_seq u_mux_bus_seq (
    .clk(clk), .rst_n(rst_n), .strap_addr_drive(strap),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .req_byte(req_byte),
    .req_region(req_region), .cfg_lo_addr_off(cfg_lo), .cfg_hi_addr_off(cfg_hi),
    .done(done), .rdata(rdata), .bus_phase(bus_phase), .ad_out(ad_out),
    .ad_oe(ad_oe), .ad_in(ad_in), .ab_out(ab_out), .ab_oe(ab_oe),
    .ahi_out(ahi_out), .ahi_oe(ahi_oe)
  );

  // {write, byte, region[1:0], lo_off, hi_off, addr[19:0], wdata[15:0], read_in[15:0]}
  localparam logic [57:0] VEC [8] = '{
    {1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 20'hA1234, 16'h0000, 16'hBEEF},
    {1'b1, 1'b0, 2'b01, 1'b1, 1'b0, 20'h05678, 16'h5A5A, 16'h0000},
    {1'b0, 1'b0, 2'b10, 1'b0, 1'b1, 20'hF9ABC, 16'h0000, 16'h1357},
    {1'b1, 1'b0, 2'b10, 1'b1, 1'b0, 20'hE0F0F, 16'hC33C, 16'h0000},
    {1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 20'h3CAFE, 16'h0000, 16'h2468},
    {1'b1, 1'b1, 2'b01, 1'b1, 1'b0, 20'h0B6E1, 16'h77C3, 16'h0000},
    {1'b0, 1'b1, 2'b10, 1'b0, 1'b0, 20'hFD4A2, 16'h0000, 16'h9A5B},
    {1'b1, 1'b0, 2'b11, 1'b1, 1'b1, 20'h81111, 16'hFFFF, 16'h0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Runs one full cycle and checks every phase. strap_hi is the strap value
  // the bench expects the design to have captured.
  task automatic run_cycle(input logic wr, input logic byt, input logic [1:0] rgn,
                           input logic lo, input logic hi, input logic [19:0] addr,
                           input logic [15:0] wd, input logic [15:0] rin,
                           input logic strap_hi, input logic hold_busy);
    logic sup;
    logic [15:0] exp_wd;
    logic [15:0] exp_rd;
    sup    = strap_hi && ((rgn == 2'b01 && lo) || (rgn == 2'b10 && hi));
    exp_wd = byt ? {8'h00, wd[7:0]} : wd;
    exp_rd = byt ? {8'h00, rin[7:0]} : rin;
    req_write = wr; req_byte = byt; req_region = rgn; cfg_lo = lo; cfg_hi = hi;
    req_addr = addr; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk); // T1
    if (hold_busy) begin
      req_addr = ~addr;
      req_wdata = ~wd;
    end else begin
      req_valid = 1'b0;
    end
    check("R1 phase T1", 32'(bus_phase), 32'd1);
    check("R10 ready low in T1", 32'(req_ready), 32'd0);
    check("R4/R5/R6 ad_oe in T1", 32'(ad_oe), 32'(!sup));
    if (!sup) check("R2 address on shared bus", 32'(ad_out), 32'(addr[15:0]));
    check("R3 ab_oe T1", 32'(ab_oe), 32'd1);
    check("R3 ab_out T1", 32'(ab_out), 32'(addr));
    check("R11 ahi_oe T1", 32'(ahi_oe), 32'(byt && !sup));
    @(negedge clk); // T2
    ad_in = rin;
    check("R1 phase T2", 32'(bus_phase), 32'd2);
    check("R8 ad_oe T2", 32'(ad_oe), 32'(wr));
    if (wr) check("R8 write data T2", 32'(ad_out), 32'(exp_wd));
    check("R3 ab_out T2", 32'(ab_out), 32'(addr));
    check("R11 ahi_oe T2", 32'(ahi_oe), 32'(byt));
    if (byt) check("R11 ahi_out T2", 32'(ahi_out), 32'(addr[15:8]));
    @(negedge clk); // T3
    req_valid = 1'b0;
    check("R1 phase T3", 32'(bus_phase), 32'd3);
    check("R9 done low T3", 32'(done), 32'd0);
    check("R8 ad_oe T3", 32'(ad_oe), 32'(wr));
    check("R3 ab_out T3", 32'(ab_out), 32'(addr));
    @(negedge clk); // T4
    ad_in = 16'h0000;
    check("R1 phase T4", 32'(bus_phase), 32'd4);
    check("R9 done T4", 32'(done), 32'd1);
    check("R8 ad_oe T4", 32'(ad_oe), 32'(wr));
    check("R3 ab_oe T4", 32'(ab_oe), 32'd1);
    if (!wr) check("R8/R9 read data", 32'(rdata), 32'(exp_rd));
    @(negedge clk); // idle
    check("R1/R10 back to idle", 32'(bus_phase), 32'd0);
    check("R9 done low idle", 32'(done), 32'd0);
    check("R10 ready idle", 32'(req_ready), 32'd1);
    check("R3 ab_oe idle", 32'(ab_oe), 32'd0);
    check("R8 ad_oe idle", 32'(ad_oe), 32'd0);
  endtask

  task automatic do_reset(input logic strap_val);
    rst_n = 1'b0;
    strap = strap_val;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    do_reset(1'b1);
    // R12 reset state
    check("R12 idle phase", 32'(bus_phase), 32'd0);
    check("R12 ready", 32'(req_ready), 32'd1);
    check("R12 done", 32'(done), 32'd0);
    check("R12 ad_oe", 32'(ad_oe), 32'd0);
    check("R12 ab_oe", 32'(ab_oe), 32'd0);
    check("R12 ahi_oe", 32'(ahi_oe), 32'd0);

    for (int i = 0; i < 8; i++) begin
      run_cycle(VEC[i][57], VEC[i][56], VEC[i][55:54], VEC[i][53], VEC[i][52],
                VEC[i][51:32], VEC[i][31:16], VEC[i][15:0], 1'b1, 1'b0);
    end

    // R10: request held high through a running cycle does not disturb it
    run_cycle(1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 20'h4C0DE, 16'h0000, 16'h6D6D, 1'b1, 1'b1);

    // R7: strap pin drops after reset; the captured high value still rules
    strap = 1'b0;
    @(negedge clk);
    run_cycle(1'b0, 1'b0, 2'b01, 1'b1, 1'b0, 20'h12345, 16'h0000, 16'hA5A5, 1'b1, 1'b0);

    // R6: strap low at reset release forces the address onto the shared bus
    do_reset(1'b0);
    strap = 1'b1;
    run_cycle(1'b0, 1'b0, 2'b01, 1'b1, 1'b1, 20'h2AAAA, 16'h0000, 16'h0F0F, 1'b0, 1'b0);
    run_cycle(1'b1, 1'b1, 2'b10, 1'b1, 1'b1, 20'h95555, 16'h3C96, 16'h0000, 1'b0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule